// File: doc/BRIEF.md
# Byte-Serial Adler-32 Accumulator with Deferred Reduction

This block computes the Adler-32 checksum of a byte stream, taking one byte per clock. It does not reduce modulo 65521 on every byte. Bytes are summed into a pair of narrow 16-bit inner sums for up to 22 bytes at a time. The inner sums are then folded into the outer sums in a single cycle. The outer low sum is kept in range with one conditional subtract. The outer high sum sits in a 32-bit register and is trimmed by a multiplier-free approximate reduction at every fold. The exact reduction runs once, after the last byte.

A message opens with a byte flagged as first and closes with a byte flagged as final. A single byte may carry both flags. A few cycles after the final byte, a one-cycle completion strobe is raised, and the 32-bit checksum is presented: the high sum in the upper half and the low sum in the lower half. The checksum then holds until the next completion.

Top module: `adler_stream`

## Requirements
- R1: During and after reset, `out_done` is 0 and `out_sum` is 0.
- R2: On `out_done`, `out_sum[15:0]` equals (1 + sum of message bytes) mod 65521. `out_sum[31:16]` equals the sum, over every byte, of the low sum after that byte, mod 65521. Both halves are below 65521.
- R3: An inner burst holds at most 22 bytes. The inner sums, including the inclusive high sum used at a fold, never wrap 16 bits, even for all-0xFF data.
- R4: The outer low sum is always below 65521, and a fold restores it with at most one subtraction of 65521.
- R5: Each fold applies the approximate reduction b − 65521·(b>>16), computed without a multiplier. The outer high sum then stays below 2^17.
- R6: A final burst shorter than 22 bytes scales the outer low sum by its own length. Every length from 1 to 50, and lengths that are exact multiples of 22, give the correct checksum.
- R7: `out_done` rises 1 to 3 cycles after the clock edge that accepts the final byte, and it stays high for exactly one cycle.
- R8: A byte with `in_valid` set is ignored if no message is open and `in_start` is low. A byte is also ignored while the block is finishing a message, whatever its flags.
- R9: `in_start` on a valid byte discards any open message and begins a new one, with that byte as its first.
- R10: `out_sum` keeps its value from one completion until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_start | input | 1 | This byte opens a message |
| in_last | input | 1 | This byte closes the message |
| in_byte | input | 8 | Data byte |
| out_done | output | 1 | One-cycle strobe: checksum ready |
| out_sum | output | 32 | Checksum, high sum in [31:16], low sum in [15:0] |

## Verification
Each message's result is compared with a byte-serial model that applies the exact modulo on every byte. Any wrong inner sum, fold count, scale factor or trim therefore shows up in `out_sum` at the completion strobe for that message, 1 to 3 cycles after its final byte.

Long all-0xFF streams drive the sums to their extremes. Sweeping lengths across the 22-byte boundary exercises the partial-burst scaling. A wrapped sum or a wrong burst limit corrupts every later fold of the message, so a single message is enough to expose it. Stray bytes sent while idle or while finishing, and a restart in mid-message, must leave the next checksum identical to the model's.

// File: rtl/adler_stream_pkg.sv
package adler_stream_pkg;

  localparam logic [31:0] ADLER_MOD = 32'd65521;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } adl_state_t;

  // x * 65521 = x*65536 - x*16 + x, valid for x below 2^16
  function automatic logic [31:0] times_mod(input logic [31:0] x);
    times_mod = (x << 16) - (x << 4) + x;
  endfunction

  // quotient estimate from the upper half, then remove that many moduli
  function automatic logic [31:0] rough_fold(input logic [31:0] b);
    logic [31:0] q;
    q = {16'd0, b[31:16]};
    rough_fold = b - times_mod(q);
  endfunction

  // one conditional subtract of the modulus
  function automatic logic [31:0] trim_once(input logic [31:0] x);
    trim_once = (x >= ADLER_MOD) ? (x - ADLER_MOD) : x;
  endfunction

  // small multiply by shift-and-add, n below 256
  function automatic logic [31:0] scale_small(input logic [15:0] a,
                                              input logic [7:0]  n);
    logic [31:0] acc;
    acc = 32'd0;
    for (int k = 0; k < 8; k++) begin
      if (n[k]) acc = acc + ({16'd0, a} << k);
    end
    scale_small = acc;
  endfunction

endpackage

// File: rtl/adler_burst_sums.sv
module adler_burst_sums
  import adler_stream_pkg::*;
#(
  parameter int BURST_LEN = 22,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic             last,
  input  logic [7:0]       byte_in,
  output logic [15:0]      a_next,
  output logic [15:0]      b_incl,
  output logic [CNT_W-1:0] n_next,
  output logic             burst_end
);

  logic [15:0]      a16, b16;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      a_cur, b_cur;
  logic [CNT_W-1:0] c_cur;
  logic [16:0]      a_wide, b_wide, i_wide;

  always_comb begin
    a_cur  = restart ? 16'd0 : a16;
    b_cur  = restart ? 16'd0 : b16;
    c_cur  = restart ? '0 : cnt;
    // high sum gathers the low sum before the byte lands in it
    b_wide = {1'b0, b_cur} + {1'b0, a_cur};
    a_wide = {1'b0, a_cur} + {9'd0, byte_in};
    i_wide = {1'b0, b_wide[15:0]} + {1'b0, a_wide[15:0]};
    a_next = a_wide[15:0];
    b_incl = i_wide[15:0];
    n_next = c_cur + CNT_W'(1);
    burst_end = take & (last | (n_next == CNT_W'(BURST_LEN)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a16 <= 16'd0;
      b16 <= 16'd0;
      cnt <= '0;
    end else if (take) begin
      if (burst_end) begin
        a16 <= 16'd0;
        b16 <= 16'd0;
        cnt <= '0;
      end else begin
        a16 <= a_next;
        b16 <= b_wide[15:0];
        cnt <= n_next;
      end
    end
  end

  // R3: no inner sum may carry out of 16 bits inside a burst
  assert_inner_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!a_wide[16] && !b_wide[16] && !i_wide[16]));

  // R3: the stored count never reaches the burst length
  assert_burst_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(BURST_LEN));

endmodule

// File: rtl/adler_outer_fold.sv
module adler_outer_fold
  import adler_stream_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [15:0]      a_old,
  input  logic [31:0]      b_old,
  input  logic [15:0]      a_in,
  input  logic [15:0]      b_in,
  input  logic [CNT_W-1:0] n,
  output logic [15:0]      a_new,
  output logic [31:0]      b_new
);

  logic [31:0] a_sum, a_trim, b_raw;

  always_comb begin
    a_sum  = {16'd0, a_old} + {16'd0, a_in};
    a_trim = trim_once(a_sum);
    a_new  = a_trim[15:0];
    // old low sum counted once per byte of this burst
    b_raw  = b_old + scale_small(a_old, 8'(n)) + {16'd0, b_in};
    b_new  = rough_fold(b_raw);
  end

  // R4: one subtract suffices after a fold
  assert_fold_a_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (a_sum <= 32'd71130) && ({16'd0, a_new} < ADLER_MOD));

  // R5: approximate fold never grows the value and keeps it small
  assert_fold_b_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (b_new <= b_raw) && (b_new < 32'h0002_0000));

endmodule

// File: rtl/adler_stream.sv
module adler_stream
  import adler_stream_pkg::*;
#(
  parameter int BURST_LEN = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [7:0]  in_byte,
  output logic        out_done,
  output logic [31:0] out_sum
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  adl_state_t       state;
  logic [15:0]      acc_a;
  logic [31:0]      acc_b;
  logic             accept, restart;
  logic             fold_evt, final_step, final_done;
  logic [15:0]      a_base;
  logic [31:0]      b_base;
  logic [15:0]      in_a, in_b, a_new;
  logic [31:0]      b_new;
  logic [CNT_W-1:0] in_n;

  always_comb begin
    accept     = in_valid && (state != ST_FINAL) &&
                 (in_start || (state == ST_RUN));
    restart    = accept && in_start;
    a_base     = restart ? 16'd1 : acc_a;
    b_base     = restart ? 32'd0 : acc_b;
    final_done = (state == ST_FINAL) && (acc_b < ADLER_MOD);
    final_step = (state == ST_FINAL) && (acc_b >= ADLER_MOD);
  end

  adler_burst_sums #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (accept),
    .restart   (restart),
    .last      (in_last),
    .byte_in   (in_byte),
    .a_next    (in_a),
    .b_incl    (in_b),
    .n_next    (in_n),
    .burst_end (fold_evt)
  );

  adler_outer_fold #(.CNT_W(CNT_W)) u_fold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (fold_evt),
    .a_old (a_base),
    .b_old (b_base),
    .a_in  (in_a),
    .b_in  (in_b),
    .n     (in_n),
    .a_new (a_new),
    .b_new (b_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      acc_a    <= 16'd1;
      acc_b    <= 32'd0;
      out_sum  <= 32'd0;
      out_done <= 1'b0;
    end else begin
      out_done <= final_done;
      if (final_done) out_sum <= {acc_b[15:0], acc_a};

      if (fold_evt) begin
        acc_a <= a_new;
        acc_b <= b_new;
      end else if (restart) begin
        acc_a <= 16'd1;
        acc_b <= 32'd0;
      end else if (final_step) begin
        acc_b <= acc_b - ADLER_MOD;
      end

      if (accept)          state <= in_last ? ST_FINAL : ST_RUN;
      else if (final_done) state <= ST_IDLE;
    end
  end

  // R4: outer low sum always in range
  assert_outer_a_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {16'd0, acc_a} < ADLER_MOD);

  // R5: outer high sum stays far from its register limit
  assert_outer_b_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_b < 32'h0002_0000);

  // R2: published halves are fully reduced
  assert_result_reduced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> ({16'd0, out_sum[15:0]} < ADLER_MOD) &&
                 ({16'd0, out_sum[31:16]} < ADLER_MOD));

  // R7: completion is a single-cycle strobe
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R10: result only moves together with the strobe
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> $stable(out_sum));

  // R8: stray bytes while idle leave the outer sums alone
  assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && in_valid && !in_start |=> $stable(acc_a) && $stable(acc_b));

endmodule

// File: tb/adler_stream_tb.sv
module adler_stream_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_start, in_last;
  logic [7:0]  in_byte;
  logic        out_done;
  logic [31:0] out_sum;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [7:0] msg [0:4095];

  always #10 clk = ~clk;

  adler_stream u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_byte(in_byte), .out_done(out_done), .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sum(input int len);
    int unsigned a, b;
    a = 1; b = 0;
    for (int i = 0; i < len; i++) begin
      a = (a + msg[i]) % 65521;
      b = (b + a) % 65521;
    end
    return {b[15:0], a[15:0]};
  endfunction

  task automatic idle_inputs();
    in_valid = 0; in_start = 0; in_last = 0; in_byte = 8'h00;
  endtask

  // send msg[0..len-1]; optional bubbles and noise while finishing
  task automatic run_msg(input int len, input bit gaps, input bit tail_noise,
                         input string req);
    int lat;
    logic [31:0] exp;
    exp = ref_sum(len);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); idle_inputs();
        in_byte = 8'h5A; // valid is low: must be ignored
      end
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_last = (i == len - 1); in_byte = msg[i];
    end
    lat = 0;
    while (lat < 8) begin
      @(negedge clk);
      lat++;
      if (lat == 1 && tail_noise) begin
        in_valid = 1; in_start = 1; in_last = 1; in_byte = 8'hC3; // R8 finishing noise
      end else idle_inputs();
      if (out_done) break;
    end
    idle_inputs();
    check(out_done === 1'b1 && lat >= 2 && lat <= 4, "R7 latency", 32'(lat), 32'd2);
    check(out_sum === exp, req, out_sum, exp);
    @(negedge clk);
    check(out_done === 1'b0, "R7 one-cycle strobe", {31'd0, out_done}, 32'd0);
  endtask

  task automatic fill_random(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom % 256);
  endtask

  task automatic fill_const(input int len, input logic [7:0] v);
    for (int i = 0; i < len; i++) msg[i] = v;
  endtask

  task automatic test_reset();
    rst_n = 0; idle_inputs();
    repeat (3) @(negedge clk);
    check(out_done === 1'b0, "R1 done in reset", {31'd0, out_done}, 32'd0);
    check(out_sum === 32'd0, "R1 sum in reset", out_sum, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check(out_sum === 32'd0 && out_done === 1'b0, "R1 after reset", out_sum, 32'd0);
  endtask

  task automatic test_lengths();
    for (int len = 1; len <= 50; len++) begin
      fill_random(len);
      run_msg(len, 1'b0, 1'b0, "R6 length sweep");
    end
    fill_random(88);
    run_msg(88, 1'b1, 1'b0, "R6 multiple of burst");
  endtask

  task automatic test_all_ff();
    fill_const(22, 8'hFF);   run_msg(22, 1'b0, 1'b0, "R3 single full burst 0xFF");
    fill_const(23, 8'hFF);   run_msg(23, 1'b0, 1'b0, "R3 burst plus one 0xFF");
    fill_const(4000, 8'hFF); run_msg(4000, 1'b0, 1'b0, "R5 long 0xFF stream");
    fill_random(3000);       run_msg(3000, 1'b1, 1'b0, "R2 long random with bubbles");
    fill_const(300, 8'h00);  run_msg(300, 1'b0, 1'b0, "R4 zero data");
  endtask

  task automatic test_ignored();
    // R8: stray bytes while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_start = 0; in_last = (i == 4); in_byte = 8'hEE;
    end
    @(negedge clk); idle_inputs();
    repeat (4) @(negedge clk);
    check(out_done === 1'b0, "R8 idle bytes raise no strobe", {31'd0, out_done}, 32'd0);
    fill_random(30);
    run_msg(30, 1'b0, 1'b1, "R8 idle and finishing bytes ignored");
    fill_random(5);
    run_msg(5, 1'b0, 1'b0, "R8 next message clean after noise");
  endtask

  task automatic test_restart();
    logic [31:0] held;
    // open a message with 10 bytes, then restart
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1; in_start = (i == 0); in_last = 0; in_byte = 8'h77;
    end
    fill_random(40);
    run_msg(40, 1'b0, 1'b0, "R9 restart discards open message");
    held = out_sum;
    repeat (20) @(negedge clk);
    check(out_sum === held, "R10 result held while idle", out_sum, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_lengths();
    test_all_ff();
    test_ignored();
    test_restart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule